// File: doc/BRIEF.md
# SD Host Card Clock Generator

This block derives the card clock of an SD/MMC host from the master clock. A divider value N selects the ratio. A nonzero N gives a square wave at the master frequency divided by 2N. A zero N passes the master clock straight through. Double-data-rate operation cannot use that pass-through, so a zero N is raised to one whenever DDR is enabled.

Alongside the card clock, the block produces two single-cycle strobes for the data paths, one for each card-clock edge. The falling-edge strobe is only produced in DDR mode. The block also selects the clock used to capture incoming data, choosing between the internally generated card clock, the clock returning on the card clock pin, and a feedback clock. The feedback clock is only usable when the high-speed bus flag is set.

Top module: `sd_card_clkgen`

## Requirements
- R1: With an effective divider N of 1 or more, `card_ck_o` is high for exactly N master cycles and low for exactly N master cycles, which gives a 50% duty cycle and a period of 2N.
- R2: With `div_i` zero and `ddr_i` low, `card_ck_o` follows `clk_i`, and `rise_o` is held high.
- R3: With `div_i` zero and `ddr_i` high, the effective divider is 1. The card clock then runs at half the master frequency.
- R4: A `div_i` request above 2^DIV_W-1 saturates to the all-ones divider 2^DIV_W-1.
- R5: A new divider value takes effect only at a falling edge of the card clock, where a complete low half starts. The high half in progress ends with the old N, and no half is shorter than the smaller of the old and new N.
- R6: In divided mode, `rise_o` is high for exactly the first master cycle of each high half of `card_ck_o`, and is low otherwise.
- R7: When DDR is enabled, `fall_o` is high for exactly the first master cycle of each low half. In SDR operation `fall_o` stays low.
- R8: `rx_ck_o` is selected by `rx_sel_i` as follows: 0 gives `card_ck_o`, 1 gives `ck_in_i`, 2 gives `fb_ck_i`, and 3 gives `card_ck_o`.
- R9: Selection 2 yields `fb_ck_i` only while `fast_bus_i` is high. Otherwise it yields `card_ck_o`.
- R10: While `rst_ni` is low, `card_ck_o`, `rise_o` and `fall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| div_i | input | REQ_W | requested divider N |
| ddr_i | input | 1 | double-data-rate enable |
| fast_bus_i | input | 1 | high-speed bus flag, set for SDR50 and faster |
| rx_sel_i | input | 2 | receive clock source select |
| ck_in_i | input | 1 | clock returning on the card clock pin |
| fb_ck_i | input | 1 | feedback clock from an external delay line |
| card_ck_o | output | 1 | card clock |
| rise_o | output | 1 | rising-edge strobe |
| fall_o | output | 1 | falling-edge strobe, DDR only |
| rx_ck_o | output | 1 | selected receive clock |

## Verification
The assertions assume that `div_i`, `ddr_i` and the select inputs are quasi-static. They may change at any master cycle, but they are not expected to toggle faster than the logic samples them. Under that assumption, the divider register changes only on a falling card-clock edge.

The bench changes these inputs only at falling master-clock edges. Each new setting is held long enough for at least one full card-clock period before anything is measured. The divider-change test deliberately switches N in the middle of a high half, to show that the switch waits for the next falling edge.

// File: rtl/sd_card_clkgen.sv
module sd_card_clkgen #(
  parameter int DIV_W = 8,
  parameter int REQ_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REQ_W-1:0] div_i,
  input  logic             ddr_i,
  input  logic             fast_bus_i,
  input  logic [1:0]       rx_sel_i,
  input  logic             ck_in_i,
  input  logic             fb_ck_i,
  output logic             card_ck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             rx_ck_o
);
  localparam logic [DIV_W-1:0] NMAX = '1;

  logic [DIV_W-1:0] n_q, cnt_q, n_nx;
  logic ck_q, ddr_q, run_q, rise_q, fall_q;
  logic bypass, last;

  always_comb begin
    n_nx = (div_i > REQ_W'(NMAX)) ? NMAX : div_i[DIV_W-1:0];
    if (n_nx == '0 && ddr_i) n_nx = DIV_W'(1);
  end

  assign bypass = (n_q == '0);
  assign last   = (cnt_q == n_q - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= '0;
      cnt_q  <= '0;
      ck_q   <= 1'b0;
      ddr_q  <= 1'b0;
      run_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (bypass) begin
        n_q   <= n_nx;
        ddr_q <= ddr_i;
        cnt_q <= '0;
        ck_q  <= 1'b0;
      end else if (last) begin
        cnt_q <= '0;
        ck_q  <= ~ck_q;
        if (ck_q) begin
          fall_q <= ddr_q;
          n_q    <= n_nx;
          ddr_q  <= ddr_i;
        end else begin
          rise_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign card_ck_o = bypass ? (clk_i & run_q) : ck_q;
  assign rise_o    = bypass ? run_q : rise_q;
  assign fall_o    = fall_q;

  always_comb begin
    case (rx_sel_i)
      2'd1:    rx_ck_o = ck_in_i;
      2'd2:    rx_ck_o = fast_bus_i ? fb_ck_i : card_ck_o;
      default: rx_ck_o = card_ck_o;
    endcase
  end

  // R1: the half-period counter never passes the divider
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass |-> cnt_q < n_q);

  // R3: DDR never coexists with the pass-through
  a_r3_ddr_divides: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ddr_q |-> n_q != '0);

  // R5: a divided-mode reload happens only on a falling card-clock edge
  a_r5_reload_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(n_q) && $past(n_q) != '0) |-> $fell(ck_q));

  // R6: rise strobe aligns with the card clock going high
  a_r6_rise_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && rise_q) |-> $rose(ck_q));

  // R7: fall strobe aligns with the card clock going low
  a_r7_fall_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> $fell(ck_q));

  // R10: outputs quiet during reset
  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!card_ck_o && !rise_o && !fall_o));
endmodule

// File: tb/sd_card_clkgen_bench.sv
module sd_card_clkgen_bench;
  localparam int DW = 4;
  localparam int RW = 6;
  localparam int NW = 100;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [RW-1:0] div_i = '0;
  logic ddr_i = 1'b0, fast_bus_i = 1'b0, ck_in_i = 1'b0, fb_ck_i = 1'b0;
  logic [1:0] rx_sel_i = 2'd0;
  logic card_ck_o, rise_o, fall_o, rx_ck_o;

  int ntot = 0, npass = 0;
  bit done = 0;
  logic lv [NW], rs [NW], fs [NW];

  always #2 clk = ~clk;

  sd_card_clkgen #(.DIV_W(DW), .REQ_W(RW)) u_sd_card_clkgen (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div_i), .ddr_i(ddr_i),
    .fast_bus_i(fast_bus_i), .rx_sel_i(rx_sel_i), .ck_in_i(ck_in_i),
    .fb_ck_i(fb_ck_i), .card_ck_o(card_ck_o), .rise_o(rise_o),
    .fall_o(fall_o), .rx_ck_o(rx_ck_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntot++;
    if (ok) npass++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  task automatic capture(input int w);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      lv[i] = card_ck_o; rs[i] = rise_o; fs[i] = fall_o;
    end
  endtask

  function automatic int eff_n(input int req, input bit ddr);
    int n = (req > (1 << DW) - 1) ? (1 << DW) - 1 : req;
    if (n == 0 && ddr) n = 1;
    return n;
  endfunction

  task automatic check_window(input int n, input bit ddr, input int req);
    int last_t = -1, bad_run = 0, bad_r = 0, bad_f = 0, runs = 0;
    for (int i = 1; i < NW; i++) begin
      if (lv[i] != lv[i-1]) begin
        if (last_t >= 0) begin
          runs++;
          if (i - last_t != n) bad_run = i - last_t;
        end
        last_t = i;
      end
      if (rs[i] != (lv[i] && !lv[i-1])) bad_r++;
      if (fs[i] != (ddr && !lv[i] && lv[i-1])) bad_f++;
    end
    chk(bad_run == 0 && runs >= 2, $sformatf("R1/R3/R4 half length req=%0d ddr=%0d", req, ddr), bad_run, n);
    chk(bad_r == 0, $sformatf("R6 rise strobe req=%0d", req), bad_r, 0);
    chk(bad_f == 0, $sformatf("R7 fall strobe req=%0d ddr=%0d", req, ddr), bad_f, 0);
  endtask

  task automatic check_bypass();
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (card_ck_o !== 1'b1 || rise_o !== 1'b1) bad++;
      @(negedge clk); #1;
      if (card_ck_o !== 1'b0 || rise_o !== 1'b1 || fall_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R2 bypass follows master clock", bad, 0);
  endtask

  task automatic switch_test(input int a, input int b);
    int last_t = -1, phase = 0, bad = 0, seen_b = 0;
    div_i = RW'(a);
    repeat (4 * a + 8) @(negedge clk);
    while (!rise_o) @(negedge clk);
    div_i = RW'(b);
    lv[0] = 1'b1;
    for (int i = 1; i < NW; i++) begin
      @(negedge clk);
      lv[i] = card_ck_o;
      if (lv[i] != lv[i-1]) begin
        if (last_t >= 0) begin
          int len = i - last_t;
          if (phase == 0 && len != a) begin
            phase = 1;
            if (lv[i-1] != 1'b0 || len != b) bad++;
            seen_b++;
          end else if (phase == 1) begin
            if (len != b) bad++;
            seen_b++;
          end
        end
        last_t = i;
      end
    end
    chk(bad == 0 && seen_b >= 2, $sformatf("R5 switch %0d->%0d at falling edge", a, b), bad, 0);
  endtask

  initial begin
    #1;
    @(negedge clk);
    chk(card_ck_o == 1'b0 && rise_o == 1'b0 && fall_o == 1'b0, "R10 outputs in reset",
        {card_ck_o, rise_o, fall_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check_bypass();

    for (int d = 0; d < 2; d++) begin
      for (int r = 0; r < 64; r++) begin
        int n;
        if (r > 18 && r < 60 && (r % 7) != 0) continue;
        ddr_i = d[0];
        div_i = RW'(r);
        n = eff_n(r, d[0]);
        repeat (4 * ((1 << DW) - 1) + 6) @(negedge clk);
        if (n == 0) check_bypass();
        else begin
          capture(NW);
          check_window(n, d[0], r);
        end
      end
    end

    ddr_i = 1'b0;
    switch_test(3, 5);
    switch_test(6, 2);

    div_i = RW'(2);
    repeat (12) @(negedge clk);
    ck_in_i = 1'b1; rx_sel_i = 2'd1; #1;
    chk(rx_ck_o == 1'b1, "R8 sel1 pin clock high", rx_ck_o, 1);
    ck_in_i = 1'b0; #1;
    chk(rx_ck_o == 1'b0, "R8 sel1 pin clock low", rx_ck_o, 0);
    rx_sel_i = 2'd2; fast_bus_i = 1'b1; fb_ck_i = 1'b1; #1;
    chk(rx_ck_o == 1'b1, "R8 sel2 feedback high", rx_ck_o, 1);
    fb_ck_i = 1'b0; #1;
    chk(rx_ck_o == 1'b0, "R8 sel2 feedback low", rx_ck_o, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      fast_bus_i = 1'b0; fb_ck_i = ~card_ck_o; #1;
      chk(rx_ck_o == card_ck_o, "R9 feedback gated without bus flag", rx_ck_o, card_ck_o);
      rx_sel_i = 2'd0; #1;
      chk(rx_ck_o == card_ck_o, "R8 sel0 internal", rx_ck_o, card_ck_o);
      rx_sel_i = 2'd3; #1;
      chk(rx_ck_o == card_ck_o, "R8 sel3 internal", rx_ck_o, card_ck_o);
      rx_sel_i = 2'd2;
    end

    while (!rise_o) @(negedge clk);
    @(posedge clk); #1;
    rst_ni = 1'b0; #1;
    chk(card_ck_o == 1'b0 && rise_o == 1'b0 && fall_o == 1'b0, "R10 async reset mid-run",
        {card_ck_o, rise_o, fall_o}, 0);
    repeat (3) @(negedge clk);
    chk(card_ck_o == 1'b0 && rise_o == 1'b0, "R10 held low in reset", {card_ck_o, rise_o}, 0);

    done = 1;
    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      ntot++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", npass, ntot);
      $finish;
    end
  end
endmodule